// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block produces the two timing strobes of a classic 8-bit microcontroller's external memory bus. It divides the oscillator clock into machine cycles of twelve clocks and drives two things: an active-high address-latch strobe, which an external latch uses to capture the low address byte, and an active-low program read strobe for external code memory. A one-clock tick marks the first clock of every machine cycle.

The core tells the block about each machine cycle through three flags. The first says the cycle is an external data transfer. The second says code is being fetched from external memory. The third is an auxiliary disable bit that limits the address strobe to data-transfer cycles. The block samples all three flags once, on the clock edge that starts a machine cycle, and holds them for the whole cycle. In an ordinary cycle the address strobe fires twice and the read strobe fires twice. During a data transfer the bus is taken over for the data access, so the second address strobe and both read strobes are left out.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n` is 1 and `mc_tick` is 0. The first machine cycle begins on the first rising clock edge after reset is released, and that cycle is phase 0.
- R2: The phase counts 0 to 11 and then wraps to 0. `mc_tick` is 1 in phase 0 and 0 in every other phase.
- R3: In a cycle with `movx_cyc`=0 and `ale_off`=0, `ale` is 1 in phases 0, 1, 6 and 7 and 0 in all other phases. This gives a strobe rate of one sixth of the clock.
- R4: In a cycle with `movx_cyc`=1 and `ale_off`=0, `ale` is 1 only in phases 0 and 1. The strobe in phases 6 and 7 is left out.
- R5: In a cycle with `ext_fetch`=1 and `movx_cyc`=0, `psen_n` is 0 in phases 3 to 5 and in phases 9 to 11, and 1 in the other phases.
- R6: `psen_n` stays 1 for the whole cycle whenever `ext_fetch`=0 or `movx_cyc`=1.
- R7: When `ale_off`=1, `ale` is 1 only in phases 0 and 1 of a cycle with `movx_cyc`=1. It stays 0 for the whole of every cycle with `movx_cyc`=0.
- R8: The three flags are sampled only on the edge that enters phase 0. A change to a flag in the middle of a cycle has no effect on `ale` or `psen_n` until the next cycle.
- R9: `ale` is never 1 in the same clock in which `psen_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| movx_cyc | input | 1 | The coming machine cycle is an external data transfer |
| ext_fetch | input | 1 | The coming machine cycle fetches code from external memory |
| ale_off | input | 1 | Auxiliary bit: limits the address strobe to data-transfer cycles |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | External program read strobe, active low |
| mc_tick | output | 1 | High in the first clock of each machine cycle |

## Verification
The embedded assertions check four properties on every cycle. Ticks only follow the last phase. Address strobes only start at a slot boundary and always last two clocks. The two strobes never overlap. The read strobe is always exactly three clocks wide.

Other behaviours can only be shown by the bench's scenarios. These are which slots get skipped for each combination of data-transfer, fetch and disable flags, and the rule that a flag change in mid-cycle takes effect only at the next cycle. The bench covers them by sweeping all eight flag combinations across whole machine cycles, once with steady flags and once with the flags inverted halfway through the cycle.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int MC_CLKS  = 12,
  parameter int ALE_W    = 2,
  parameter int PSEN_GAP = 1,
  parameter int PSEN_W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic movx_cyc,
  input  logic ext_fetch,
  input  logic ale_off,
  output logic ale,
  output logic psen_n,
  output logic mc_tick
);
  localparam int HALF  = MC_CLKS / 2;
  localparam int CW    = $clog2(MC_CLKS);
  localparam int PS_LO = ALE_W + PSEN_GAP;
  localparam int PS_HI = PS_LO + PSEN_W;

  logic [CW-1:0] ph;
  logic [CW-1:0] sub;
  logic          last, second, in_ale, in_ps;
  logic          movx_q, fetch_q, off_q;

  assign last   = (ph == CW'(MC_CLKS - 1));
  assign second = (ph >= CW'(HALF));
  assign sub    = second ? ph - CW'(HALF) : ph;
  assign in_ale = (sub < CW'(ALE_W));
  assign in_ps  = (sub >= CW'(PS_LO)) && (sub < CW'(PS_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= CW'(MC_CLKS - 1);
      movx_q  <= 1'b0;
      fetch_q <= 1'b0;
      off_q   <= 1'b0;
    end else if (last) begin
      ph      <= '0;
      movx_q  <= movx_cyc;
      fetch_q <= ext_fetch;
      off_q   <= ale_off;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign mc_tick = (ph == '0);
  assign ale     = in_ale & (off_q ? (movx_q & ~second) : ~(movx_q & second));
  assign psen_n  = ~(in_ps & fetch_q & ~movx_q);

  assert_tick_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mc_tick |-> $past(last));

  assert_ale_slot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (ph == '0 || ph == CW'(HALF)));

  assert_ale_two_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  assert_psen_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));
endmodule

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic movx_cyc = 1'b0, ext_fetch = 1'b0, ale_off = 1'b0;
  logic ale, psen_n, mc_tick;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst_n(rst_n), .movx_cyc(movx_cyc), .ext_fetch(ext_fetch),
    .ale_off(ale_off), .ale(ale), .psen_n(psen_n), .mc_tick(mc_tick)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic run_cycle(bit mv, bit fe, bit of, bit flip);
    movx_cyc = mv; ext_fetch = fe; ale_off = of;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      begin
        bit a_slot = (k < 2) || (k >= 6 && k < 8);
        bit first  = (k < 6);
        bit p_slot = (k >= 3 && k < 6) || (k >= 9);
        bit ale_e  = of ? (mv && k < 2) : (a_slot && !(mv && !first));
        bit psn_e  = !(fe && !mv && p_slot);
        string ta  = flip ? "R8" : (of ? "R7" : (mv ? "R4" : "R3"));
        string tp  = flip ? "R8" : ((fe && !mv) ? "R5" : "R6");
        chk(ta, "ale", ale, ale_e);
        chk(tp, "psen_n", psen_n, psn_e);
        chk("R2", "mc_tick", mc_tick, k == 0);
        chk("R9", "overlap", ale && !psen_n, 1'b0);
      end
      if (flip && k == 5) begin
        movx_cyc = !mv; ext_fetch = !fe; ale_off = !of;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ale in reset", ale, 1'b0);
    chk("R1", "psen_n in reset", psen_n, 1'b1);
    chk("R1", "mc_tick in reset", mc_tick, 1'b0);
    rst_n = 1'b1;
    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 8; c++)
        run_cycle(c[0], c[1], c[2], rep == 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule